// File: doc/BRIEF.md
# SIMD Floating-Point Exception Controller

This block sits beside a multi-lane SIMD floating-point datapath. It gathers per-lane exception conditions, turns them into sticky status flags in a 16-bit control/status word, and decides whether each instruction raises a trap request. It also tells the datapath whether to commit the masked default results or to suppress the write.

Each instruction is judged in two ordered phases. When the instruction issues, the operand-side conditions arrive and are judged first: invalid operand, divide-by-zero and denormal operand. After that, once the datapath presents its result, the result-side conditions are judged: overflow, underflow and inexact. Each phase raises its own trap pulse, so one instruction can trap twice. A denormals-as-zero mode bit hides the denormal-operand condition. A flush-to-zero mode bit makes the block request that underflowing lanes be replaced with zero, and those lanes are then also reported as inexact.

A state machine drives the sequence. Its states are `ST_IDLE`, `ST_PRE_EVAL`, `ST_WAIT_RES` and `ST_POST_EVAL`. Its transitions are:
- IDLE→PRE_EVAL when `issue` is high.
- PRE_EVAL→WAIT_RES always.
- WAIT_RES→POST_EVAL when `res_valid` is high.
- POST_EVAL→IDLE always.

Top module: `simd_fpx_ctrl`

## Requirements
- R1: After reset the control/status word reads 0x1F80, meaning all six masks are set and all flags and modes are clear. `busy`, `trap`, `wb_commit`, `wb_suppress` and `flush_zero` are all low.
- R2: A write loads the word into bits 0–12 and 15. Bits 13 and 14 always read 0. The bit layout is as follows:
  - Flags sit in bits 0–5, in the order invalid, denormal, divide-by-zero, overflow, underflow, inexact.
  - Masks sit in bits 7–12, in the same order.
  - Bit 6 is denormals-as-zero.
  - Bit 15 is flush-to-zero.
- R3: At the end of `ST_PRE_EVAL`, each of the invalid, denormal and divide-by-zero flags is ORed with the OR of its condition over the lanes that were active at issue. Inactive lanes have no effect.
- R4: When denormals-as-zero is 1, the denormal-operand condition is not reported and cannot trap.
- R5: During `ST_PRE_EVAL`, the cycle after issue is accepted, `trap` pulses with `trap_phase`=0 if any reported operand-side condition has its mask bit clear.
- R6: At the end of `ST_POST_EVAL`, each of the overflow, underflow and inexact flags is ORed with the OR of its condition over the active lanes. These conditions are taken only when `res_valid` is accepted.
- R7: During `ST_POST_EVAL`, the cycle after `res_valid` is accepted, `trap` pulses with `trap_phase`=1 if any reported result-side condition is unmasked.
- R8: When an instruction has unmasked conditions in both phases, `trap` pulses twice. The phase-0 pulse comes first, and at least one cycle separates the two pulses.
- R9: When flush-to-zero is 1 and the underflow mask is set, the following apply in `ST_POST_EVAL`:
  - `flush_zero` marks each active underflowing lane.
  - Those lanes also report inexact.
  - Otherwise `flush_zero` is 0.
- R10: The denormals-as-zero bit has no effect on how underflow or inexact are reported.
- R11: In `ST_POST_EVAL`, `wb_commit` pulses if neither phase trapped. Otherwise `wb_suppress` pulses.
- R12: Flags are sticky: a flag falls only through a write.
- R13: Every trap pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Write the control/status word |
| csr_wr_data | input | 16 | Value to write |
| csr_rd_data | output | 16 | Current control/status word |
| issue | input | 1 | Instruction issue, accepted in ST_IDLE |
| lane_active | input | LANES | Lanes taking part, captured at issue |
| pre_inv | input | LANES | Per-lane invalid-operand condition |
| pre_den | input | LANES | Per-lane denormal-operand condition |
| pre_dz | input | LANES | Per-lane divide-by-zero condition |
| res_valid | input | 1 | Result-side conditions valid, accepted in ST_WAIT_RES |
| post_ovf | input | LANES | Per-lane overflow condition |
| post_unf | input | LANES | Per-lane underflow condition |
| post_inx | input | LANES | Per-lane inexact condition |
| busy | output | 1 | An instruction is in flight |
| trap | output | 1 | One-cycle trap request |
| trap_phase | output | 1 | 0 = operand-side trap, 1 = result-side trap |
| wb_commit | output | 1 | Write back the masked default results |
| wb_suppress | output | 1 | Suppress the write |
| flush_zero | output | LANES | Lanes whose result is to be replaced by zero |

## Verification
The assertions check several properties on every cycle:
- Trap pulses are single-cycle.
- An operand-side trap only follows an accepted issue, and a result-side trap only follows an accepted result.
- Flags never fall without a write, and the reserved bits stay zero.
- Flush requests only appear under flush-to-zero.
- The denormal flag is never set while denormals-as-zero is on.

Other behaviours can only be shown by the bench's scenarios:
- The exact flag values ORed over active lanes.
- The trap decision against each mask combination, including the double trap.
- The inexact side effect of flushing.
- The choice between commit and suppress.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int CSR_W     = 16;
    localparam int FLAG_N    = 6;
    localparam int MASK_LSB  = 7;
    localparam int DAZ_BIT   = 6;
    localparam int FTZ_BIT   = 15;
    localparam logic [CSR_W-1:0] CSR_WR_MASK = 16'h9FFF;
    localparam logic [CSR_W-1:0] CSR_RST     = 16'h1F80;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE_EVAL,
        ST_WAIT_RES,
        ST_POST_EVAL
    } seq_state_e;

    typedef struct packed {
        logic prec;
        logic unf;
        logic ovf;
        logic dz;
        logic den;
        logic inv;
    } fpx_flags_t;
endpackage

// File: rtl/fpx_lane_reduce.sv
module fpx_lane_reduce #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] active,
    input  logic [LANES-1:0] cond_a,
    input  logic [LANES-1:0] cond_b,
    input  logic [LANES-1:0] cond_c,
    output logic [2:0]       any
);
    logic [LANES-1:0] hit_a, hit_b, hit_c;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit_a[g] = cond_a[g] & active[g];
        assign hit_b[g] = cond_b[g] & active[g];
        assign hit_c[g] = cond_c[g] & active[g];
    end

    assign any = {|hit_c, |hit_b, |hit_a};
endmodule

// File: rtl/fpx_csr.sv
module fpx_csr
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic [FLAG_N-1:0] set_flags,
    output logic [CSR_W-1:0] csr_q
);
    logic [CSR_W-1:0] base;

    always_comb begin
        base = wr_en ? (wr_data & CSR_WR_MASK) : csr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) csr_q <= CSR_RST;
        else        csr_q <= base | {{(CSR_W-FLAG_N){1'b0}}, set_flags};
    end

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !$past(wr_en) |-> ((csr_q[FLAG_N-1:0] & $past(csr_q[FLAG_N-1:0])) == $past(csr_q[FLAG_N-1:0]))); // R12
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) csr_q[14:13] == 2'b00); // R2
endmodule

// File: rtl/fpx_seq.sv
module fpx_seq
    import fpx_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              res_valid,
    input  logic [LANES-1:0]  lane_active,
    input  logic [LANES-1:0]  pre_inv,
    input  logic [LANES-1:0]  pre_den,
    input  logic [LANES-1:0]  pre_dz,
    input  logic [LANES-1:0]  post_ovf,
    input  logic [LANES-1:0]  post_unf,
    input  logic [LANES-1:0]  post_inx,
    input  logic [FLAG_N-1:0] masks,
    input  logic              daz,
    input  logic              ftz,
    output logic [FLAG_N-1:0] set_flags,
    output logic              busy,
    output logic              trap,
    output logic              trap_phase,
    output logic              wb_commit,
    output logic              wb_suppress,
    output logic [LANES-1:0]  flush_zero
);
    seq_state_e state_q, state_d;

    logic [LANES-1:0] act_q, inv_q, den_q, dz_q, ovf_q, unf_q, inx_q;
    logic             pre_hit_q;
    logic [2:0]       pre_any, post_any;
    logic [LANES-1:0] flush_vec, inx_eff;
    logic             ftz_active;
    fpx_flags_t       pre_f, post_f;
    logic             pre_unm, post_unm;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (issue) state_d = ST_PRE_EVAL;
            ST_PRE_EVAL:  state_d = ST_WAIT_RES;
            ST_WAIT_RES:  if (res_valid) state_d = ST_POST_EVAL;
            ST_POST_EVAL: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // capture of lane conditions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0; inv_q <= '0; den_q <= '0; dz_q <= '0;
            ovf_q <= '0; unf_q <= '0; inx_q <= '0;
            pre_hit_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && issue) begin
                act_q <= lane_active;
                inv_q <= pre_inv;
                den_q <= pre_den;
                dz_q  <= pre_dz;
                pre_hit_q <= 1'b0;
            end
            if (state_q == ST_PRE_EVAL) pre_hit_q <= pre_unm;
            if (state_q == ST_WAIT_RES && res_valid) begin
                ovf_q <= post_ovf;
                unf_q <= post_unf;
                inx_q <= post_inx;
            end
        end
    end

    // flush-to-zero applies only while the underflow mask is set
    assign ftz_active = ftz & masks[4];

    for (genvar g = 0; g < LANES; g++) begin : g_ftz
        assign flush_vec[g] = ftz_active & unf_q[g] & act_q[g];
        assign inx_eff[g]   = inx_q[g] | flush_vec[g];
    end

    fpx_lane_reduce #(.LANES(LANES)) u_pre_red (
        .active (act_q),
        .cond_a (inv_q),
        .cond_b (den_q),
        .cond_c (dz_q),
        .any    (pre_any)
    );

    fpx_lane_reduce #(.LANES(LANES)) u_post_red (
        .active (act_q),
        .cond_a (ovf_q),
        .cond_b (unf_q),
        .cond_c (inx_eff),
        .any    (post_any)
    );

    always_comb begin
        pre_f      = '0;
        pre_f.inv  = pre_any[0];
        pre_f.den  = pre_any[1] & ~daz;
        pre_f.dz   = pre_any[2];
        post_f      = '0;
        post_f.ovf  = post_any[0];
        post_f.unf  = post_any[1];
        post_f.prec = post_any[2];
        pre_unm  = |(pre_f  & ~masks);
        post_unm = |(post_f & ~masks);
    end

    // outputs per state
    always_comb begin
        set_flags   = '0;
        trap        = 1'b0;
        trap_phase  = 1'b0;
        wb_commit   = 1'b0;
        wb_suppress = 1'b0;
        flush_zero  = '0;
        busy        = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE_EVAL: begin
                set_flags = pre_f;
                trap      = pre_unm;
            end
            ST_WAIT_RES: ;
            ST_POST_EVAL: begin
                set_flags   = post_f;
                trap        = post_unm;
                trap_phase  = 1'b1;
                wb_commit   = ~pre_hit_q & ~post_unm;
                wb_suppress = pre_hit_q | post_unm;
                flush_zero  = flush_vec;
            end
            default: ;
        endcase
    end

    AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) trap |=> !trap); // R13
    AST_PRE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) (trap && !trap_phase) |-> $past(issue)); // R5
    AST_POST_AFTER_RES: assert property (@(posedge clk) disable iff (!rst_n) (trap && trap_phase) |-> $past(res_valid)); // R7
    AST_FLUSH_NEEDS_FTZ: assert property (@(posedge clk) disable iff (!rst_n) (|flush_zero) |-> ftz); // R9
    AST_DAZ_HIDES_DEN: assert property (@(posedge clk) disable iff (!rst_n) daz |-> !set_flags[1]); // R4
endmodule

// File: rtl/simd_fpx_ctrl.sv
module simd_fpx_ctrl
    import fpx_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr_en,
    input  logic [15:0]      csr_wr_data,
    output logic [15:0]      csr_rd_data,
    input  logic             issue,
    input  logic [LANES-1:0] lane_active,
    input  logic [LANES-1:0] pre_inv,
    input  logic [LANES-1:0] pre_den,
    input  logic [LANES-1:0] pre_dz,
    input  logic             res_valid,
    input  logic [LANES-1:0] post_ovf,
    input  logic [LANES-1:0] post_unf,
    input  logic [LANES-1:0] post_inx,
    output logic             busy,
    output logic             trap,
    output logic             trap_phase,
    output logic             wb_commit,
    output logic             wb_suppress,
    output logic [LANES-1:0] flush_zero
);
    logic [CSR_W-1:0]  csr_q;
    logic [FLAG_N-1:0] set_flags;

    fpx_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (csr_wr_en),
        .wr_data   (csr_wr_data),
        .set_flags (set_flags),
        .csr_q     (csr_q)
    );

    fpx_seq #(.LANES(LANES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .res_valid   (res_valid),
        .lane_active (lane_active),
        .pre_inv     (pre_inv),
        .pre_den     (pre_den),
        .pre_dz      (pre_dz),
        .post_ovf    (post_ovf),
        .post_unf    (post_unf),
        .post_inx    (post_inx),
        .masks       (csr_q[MASK_LSB+FLAG_N-1:MASK_LSB]),
        .daz         (csr_q[DAZ_BIT]),
        .ftz         (csr_q[FTZ_BIT]),
        .set_flags   (set_flags),
        .busy        (busy),
        .trap        (trap),
        .trap_phase  (trap_phase),
        .wb_commit   (wb_commit),
        .wb_suppress (wb_suppress),
        .flush_zero  (flush_zero)
    );

    assign csr_rd_data = csr_q;

    AST_COMMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) wb_commit |-> (!trap && !wb_suppress)); // R11
endmodule

// File: tb/simd_fpx_ctrl_bench.sv
module simd_fpx_ctrl_bench;
    localparam int L = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csr_wr_en = 1'b0;
    logic [15:0] csr_wr_data = '0;
    logic [15:0] csr_rd_data;
    logic issue = 1'b0, res_valid = 1'b0;
    logic [L-1:0] lane_active = '0, pre_inv = '0, pre_den = '0, pre_dz = '0;
    logic [L-1:0] post_ovf = '0, post_unf = '0, post_inx = '0;
    logic busy, trap, trap_phase, wb_commit, wb_suppress;
    logic [L-1:0] flush_zero;

    int total = 0;
    int bad = 0;
    logic [15:0] model;

    always #2.5 clk = ~clk;

    simd_fpx_ctrl #(.LANES(L)) u_simd_fpx_ctrl (
        .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
        .csr_rd_data(csr_rd_data), .issue(issue), .lane_active(lane_active),
        .pre_inv(pre_inv), .pre_den(pre_den), .pre_dz(pre_dz), .res_valid(res_valid),
        .post_ovf(post_ovf), .post_unf(post_unf), .post_inx(post_inx), .busy(busy),
        .trap(trap), .trap_phase(trap_phase), .wb_commit(wb_commit),
        .wb_suppress(wb_suppress), .flush_zero(flush_zero)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_pre(input logic [L-1:0] a, i, d, z, input logic [15:0] c);
        exp_pre = {3'b000, |(z & a), c[6] ? 1'b0 : |(d & a), |(i & a)};
    endfunction

    function automatic logic [L-1:0] exp_flush(input logic [L-1:0] a, u, input logic [15:0] c);
        exp_flush = (c[15] && c[11]) ? (u & a) : '0;
    endfunction

    function automatic logic [5:0] exp_post(input logic [L-1:0] a, o, u, x, input logic [15:0] c);
        exp_post = {|(x & a) | (|exp_flush(a, u, c)), |(u & a), |(o & a), 3'b000};
    endfunction

    task automatic write_csr(input logic [15:0] v);
        @(negedge clk);
        csr_wr_en = 1'b1; csr_wr_data = v;
        @(posedge clk);
        @(negedge clk);
        csr_wr_en = 1'b0;
        model = v & 16'h9FFF;
        check("R2 write", csr_rd_data, model);
    endtask

    task automatic run_instr(input logic [L-1:0] a, i, d, z, o, u, x);
        logic [5:0] pf, qf;
        logic pt, qt;
        @(negedge clk);
        issue = 1'b1; lane_active = a; pre_inv = i; pre_den = d; pre_dz = z;
        @(posedge clk);
        @(negedge clk);
        issue = 1'b0; lane_active = '1; pre_inv = '1; pre_den = '1; pre_dz = '1;
        pf = exp_pre(a, i, d, z, model);
        pt = |(pf & ~model[12:7]);
        check("R5 pre trap", trap, pt);
        check("R5 pre phase", trap & trap_phase, 1'b0);
        model = model | {10'b0, pf};
        @(posedge clk);
        @(negedge clk);
        check("R3 R4 pre flags", csr_rd_data, model);
        check("R13 gap", trap, 1'b0);
        res_valid = 1'b1; post_ovf = o; post_unf = u; post_inx = x;
        @(posedge clk);
        @(negedge clk);
        res_valid = 1'b0; post_ovf = '1; post_unf = '1; post_inx = '1;
        qf = exp_post(a, o, u, x, model);
        qt = |(qf & ~model[12:7]);
        check("R7 R8 post trap", trap, qt);
        if (qt) check("R7 post phase", trap_phase, 1'b1);
        check("R11 commit", wb_commit, !(pt || qt));
        check("R11 suppress", wb_suppress, pt || qt);
        check("R9 flush", flush_zero, exp_flush(a, u, model));
        model = model | {10'b0, qf};
        @(posedge clk);
        @(negedge clk);
        check("R6 R10 R12 post flags", csr_rd_data, model);
        check("R13 idle", {busy, trap}, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model = 16'h1F80;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 csr reset", csr_rd_data, 16'h1F80);
        check("R1 outputs", {busy, trap, wb_commit, wb_suppress, flush_zero}, '0);
        // R1 all masked: conditions everywhere, no trap, commit
        run_instr(4'hF, 4'h1, 4'h2, 4'h4, 4'h8, 4'h1, 4'h2);
        // R2 reserved bits dropped, flags cleared by write
        write_csr(16'hFFFF);
        write_csr(16'h0000);
        // R3 inactive lanes ignored even with all unmasked
        run_instr(4'h0, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF);
        // R8 double trap: both phases unmasked
        run_instr(4'h3, 4'h2, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0);
        // R4 denormals-as-zero hides denormal; R10 underflow still reported
        write_csr(16'h0040);
        run_instr(4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 4'h4, 4'h0);
        // R9 flush-to-zero with underflow masked: flush + inexact
        write_csr(16'h8000 | 16'h0800 | 16'h0F80);
        run_instr(4'h5, 4'h0, 4'h0, 4'h0, 4'h0, 4'h7, 4'h0);
        // R9 flush-to-zero with underflow unmasked: no flush, trap
        write_csr(16'h8000 | 16'h1780);
        run_instr(4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h2, 4'h0);
        // R12 sticky through a quiet instruction
        run_instr(4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0);
        // random mix
        for (int n = 0; n < 300; n++) begin
            if ($urandom_range(0, 3) == 0)
                write_csr(16'($urandom) & 16'h9FFF);
            run_instr(L'($urandom), L'($urandom & $urandom), L'($urandom & $urandom),
                      L'($urandom & $urandom), L'($urandom & $urandom),
                      L'($urandom & $urandom), L'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule